// File: doc/BRIEF.md
# External Interrupt Controller with Per-Source Gateways

The controller gathers eight external interrupt requests for a 32-bit core. Each request first passes an optional inverter, which lets active-low sources be used. It then enters its own gateway, set to level or edge mode. In level mode the pending bit tracks the request. In edge mode a rising edge is latched and held until software clears it.

Pending sources that are enabled and whose priority is above a global threshold compete for the claim. The winner's ID (source index plus one, with zero meaning none) is registered together with a handler-pointer address. That address is built from a 1 KiB-aligned table base, the claim ID and two zero bits. A single request line to the core is raised whenever a claim is present.

All configuration, the pending status, the gateway clear and the handler address are reached through a small word-addressed register port. Writes are synchronous. Reads are combinational from the address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the following are all zero: pending, enables, polarity, mode, threshold, priorities, table base, claim ID and `ext_irq`.
- R2: A gateway with mode bit 0 (level) copies its polarity-adjusted input into its pending bit one clock later. A request that stays asserted keeps the source pending and claimable indefinitely.
- R3: Polarity register (byte address 0x0C) bit i set to 1 inverts input i before its gateway.
- R4: A gateway with mode bit 1 (edge, mode register at 0x10) sets pending on a rising edge of its adjusted input. Pending then holds after the input falls. Further edges while pending change nothing.
- R5: A write to 0x18 with source index i in wdata[7:0] clears the latched pending bit of edge-mode source i. For a level-mode source the pending bit still reflects the input.
- R6: Reading 0x14 returns the pending vector, with bit i for source i.
- R7: A source is eligible when it is pending, enabled (0x08 bit i) and its 4-bit priority (0x20+4*i) is strictly above the threshold (0x04). The claim ID is i+1 of the eligible source with the highest priority. Ties go to the lower index. With no eligible source the claim ID is 0.
- R8: `ext_irq` is 1 exactly when the claim ID is non-zero.
- R9: The table base at 0x00 keeps only bits [31:10]. The handler address (output, and readable at 0x1C) equals base[31:10], then claim ID in [9:2], then 00.
- R10: Claim ID, handler address and `ext_irq` change together, one clock after the pending bits change (two clocks after an input change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | External request inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ext_irq | output | 1 | External interrupt request to the core |
| claim_id | output | 8 | Winning source ID, 0 = none |
| handler_addr | output | 32 | Handler-pointer address |

## Verification
Every cycle, assertions check three things. A level gateway tracks its adjusted input. An edge gateway never drops pending without a clear. Any non-zero claim names a source that was pending, enabled and above threshold one cycle earlier. Two properties need the scenarios: the winner is the maximum-priority, lowest-index source, and the handler address packs its fields correctly. The bench shows both by sweeping all 256 request patterns under two enable masks and comparing against an arithmetic model. Polarity inversion, edge hold and ignore, the effect of clears on each mode, and the one-cycle lag of the claim also depend on stimulus order, and only the directed scenarios show them.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ext_irq,
  output logic [7:0]        claim_id,
  output logic [31:0]       handler_addr
);
  localparam int ID_W      = 8;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int PRIO_BASE = 8;
  localparam logic [IDX_W-1:0] A_BASE = IDX_W'(0);
  localparam logic [IDX_W-1:0] A_THR  = IDX_W'(1);
  localparam logic [IDX_W-1:0] A_EN   = IDX_W'(2);
  localparam logic [IDX_W-1:0] A_POL  = IDX_W'(3);
  localparam logic [IDX_W-1:0] A_MODE = IDX_W'(4);
  localparam logic [IDX_W-1:0] A_PEND = IDX_W'(5);
  localparam logic [IDX_W-1:0] A_CLR  = IDX_W'(6);
  localparam logic [IDX_W-1:0] A_HADR = IDX_W'(7);

  logic [IDX_W-1:0]  idx;
  logic [21:0]       base_q;
  logic [PRIO_W-1:0] thr_q;
  logic [NSRC-1:0]   en_q, pol_q, mode_q, pend_q, prev_q, raw, clr_vec;
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [ID_W-1:0]   best_id, claim_q;
  logic [PRIO_W-1:0] best_p;
  logic              irq_q;

  assign idx = reg_addr[ADDR_W-1:2];
  assign raw = irq_in ^ pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      thr_q  <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      case (idx)
        A_BASE: base_q <= reg_wdata[31:10];
        A_THR:  thr_q  <= reg_wdata[PRIO_W-1:0];
        A_EN:   en_q   <= reg_wdata[NSRC-1:0];
        A_POL:  pol_q  <= reg_wdata[NSRC-1:0];
        A_MODE: mode_q <= reg_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [ID_W-1:0]  MY_IDX = ID_W'(i);
    localparam logic [ID_W-1:0]  MY_ID  = ID_W'(i + 1);
    localparam logic [IDX_W-1:0] MY_PA  = IDX_W'(PRIO_BASE + i);

    assign clr_vec[i] = reg_we && idx == A_CLR && reg_wdata[ID_W-1:0] == MY_IDX;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        pend_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        if (reg_we && idx == MY_PA) prio_q[i] <= reg_wdata[PRIO_W-1:0];
        prev_q[i] <= raw[i];
        if (mode_q[i]) pend_q[i] <= (pend_q[i] & ~clr_vec[i]) | (raw[i] & ~prev_q[i]);
        else           pend_q[i] <= raw[i];
      end
    end

    assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(mode_q[i]) |-> pend_q[i] == ($past(irq_in[i]) ^ $past(pol_q[i])));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(mode_q[i]) && $past(pend_q[i]) && !$past(clr_vec[i]) |-> pend_q[i]);

    assert_claim_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed && claim_q == MY_ID |-> $past(pend_q[i] && en_q[i] && prio_q[i] > thr_q));
  end

  always_comb begin
    best_id = '0;
    best_p  = thr_q;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && en_q[i] && prio_q[i] > best_p) begin
        best_p  = prio_q[i];
        best_id = ID_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      claim_q <= best_id;
      irq_q   <= best_id != '0;
    end
  end

  assign claim_id     = claim_q;
  assign ext_irq      = irq_q;
  assign handler_addr = {base_q, claim_q, 2'b00};

  always_comb begin
    reg_rdata = '0;
    case (idx)
      A_BASE: reg_rdata = {base_q, 10'b0};
      A_THR:  reg_rdata = 32'(thr_q);
      A_EN:   reg_rdata = 32'(en_q);
      A_POL:  reg_rdata = 32'(pol_q);
      A_MODE: reg_rdata = 32'(mode_q);
      A_PEND: reg_rdata = 32'(pend_q);
      A_HADR: reg_rdata = handler_addr;
      default:
        for (int i = 0; i < NSRC; i++)
          if (idx == IDX_W'(PRIO_BASE + i)) reg_rdata = 32'(prio_q[i]);
    endcase
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_irq_has_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ext_irq |-> $past(pend_q & en_q) != '0);

  assert_claim_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_q <= ID_W'(NSRC));
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  irq_in = '0;
  logic        reg_we = 0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_irq;
  logic [7:0]  claim_id;
  logic [31:0] handler_addr;
  int checks = 0, fails = 0;
  logic [3:0]  bprio [8];
  logic [3:0]  bthr = 0;
  logic [31:0] bbase = 0;

  ext_irq_ctrl uut (.clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata,
                    .reg_rdata, .ext_irq, .claim_id, .handler_addr);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_id(input logic [7:0] p, input logic [7:0] e);
    logic [7:0] id = 0;
    logic [3:0] bp = bthr;
    for (int i = 0; i < 8; i++)
      if (p[i] && e[i] && bprio[i] > bp) begin bp = bprio[i]; id = 8'(i + 1); end
    return id;
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 claim", 32'(claim_id), 0);
    chk("R1 irq", 32'(ext_irq), 0);
    rd(7'h14, d); chk("R1 pending", d, 0);
    rd(7'h08, d); chk("R1 enable", d, 0);
    rd(7'h10, d); chk("R1 mode", d, 0);
    rd(7'h20, d); chk("R1 prio0", d, 0);
    // R9 base alignment
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, d); chk("R9 base keeps [31:10]", d, 32'hFFFF_FC00);
    bbase = 32'h8000_0400;
    wr(7'h00, bbase);
    for (int i = 0; i < 8; i++) begin
      bprio[i] = 4'((i * 5 + 3) % 16);
      wr(7'(32 + 4 * i), 32'(bprio[i]));
    end
    bthr = 2;
    wr(7'h04, 32'(bthr));
    // R6 R7 R8 R9 exhaustive sweep over request patterns and two enable masks
    for (int m = 0; m < 2; m++) begin
      e = (m == 0) ? 8'hFF : 8'h5A;
      wr(7'h08, 32'(e));
      for (int p = 0; p < 256; p++) begin
        irq_in = 8'(p);
        settle();
        rd(7'h14, d); chk("R6 pending", d, 32'(p));
        chk("R7 claim", 32'(claim_id), 32'(exp_id(8'(p), e)));
        chk("R8 irq", 32'(ext_irq), 32'(exp_id(8'(p), e) != 0));
        chk("R9 handler", handler_addr, {bbase[31:10], exp_id(8'(p), e), 2'b00});
        rd(7'h1C, d); chk("R9 handler read", d, handler_addr);
      end
    end
    // R7 ties to lower index, threshold strict
    for (int i = 0; i < 8; i++) begin bprio[i] = 9; wr(7'(32 + 4 * i), 9); end
    wr(7'h08, 32'hFF);
    irq_in = 8'b1010_0100; settle();
    chk("R7 tie lower id", 32'(claim_id), 3);
    bthr = 9; wr(7'h04, 9); settle();
    chk("R7 threshold equal blocks", 32'(claim_id), 0);
    bthr = 0; wr(7'h04, 0);
    // R10 timing: pending moves first, claim one clock later
    irq_in = 0; settle();
    @(negedge clk); irq_in = 8'h02;
    @(posedge clk); @(negedge clk);
    rd(7'h14, d); chk("R10 pending after 1 clk", d, 2);
    chk("R10 claim still old", 32'(claim_id), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 claim after 2 clk", 32'(claim_id), 2);
    chk("R10 irq with claim", 32'(ext_irq), 1);
    // R2 level request persists
    repeat (10) @(negedge clk);
    chk("R2 level retrigger", 32'(claim_id), 2);
    irq_in = 0; settle();
    chk("R2 level drops", 32'(claim_id), 0);
    // R3 polarity
    wr(7'h0C, 32'h08); settle();
    rd(7'h14, d); chk("R3 inverted idle pends", d, 32'h08);
    irq_in = 8'h08; settle();
    rd(7'h14, d); chk("R3 inverted active clears", d, 0);
    irq_in = 0; wr(7'h0C, 0);
    // R4 edge latch and hold
    wr(7'h10, 32'h20); settle();
    irq_in = 8'h20; settle();
    irq_in = 0; settle();
    rd(7'h14, d); chk("R4 edge held", d, 32'h20);
    chk("R4 edge claim", 32'(claim_id), 6);
    irq_in = 8'h20; settle(); irq_in = 0; settle();
    rd(7'h14, d); chk("R4 edge while pending", d, 32'h20);
    // R5 clear of other source does nothing, own index clears
    wr(7'h18, 4); settle();
    rd(7'h14, d); chk("R5 other clear ignored", d, 32'h20);
    wr(7'h18, 5); settle();
    rd(7'h14, d); chk("R5 edge cleared", d, 0);
    chk("R5 claim gone", 32'(claim_id), 0);
    irq_in = 8'h01; settle();
    wr(7'h18, 0); settle();
    rd(7'h14, d); chk("R5 level not cleared", d, 32'h01);
    irq_in = 0; settle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule